// File: doc/BRIEF.md
# DMA Channel Address Generator

This block holds the source and destination address pointers of one DMA channel that moves data with two addresses per transfer (a read address and a write address). Software or a channel controller loads both start addresses with a load strobe. After that, each transfer-done pulse advances both pointers together in the same clock cycle. Each pointer moves according to its own direction setting and its own step-position setting. The block does no bus signalling, no counting of bytes and no data movement. It only supplies the two addresses that the transfer engine uses next.

Each pointer can be set to count up, count down or stay fixed. A pointer that faces an I/O port is always held fixed. The step is normally the transfer width: 1, 2 or 4 bytes. A 3-bit position code can instead apply the step at address bit 4, 8, 12 or 16. This gives strided walks of 16, 256, 4096 or 65536 bytes, whatever the transfer width. Reserved position codes fall back to the normal width step and raise a configuration-error flag. All address arithmetic wraps modulo 2^32.

Top module: `dmaag_addr_gen`

## Requirements
- R1: In the first cycle after reset (synchronous, active-high `rst`), both address outputs read 0 and `cfg_err_o` reads 0.
- R2: A `load_i` pulse makes `src_addr_o` and `dst_addr_o` show `src_init_i` and `dst_init_i` one clock later, without any step. These are the addresses of the first transfer.
- R3: When `load_i` and `done_i` are high in the same cycle, the load wins. The new start addresses appear with no step applied.
- R4: Direction codes: 2'b01 counts up, 2'b10 counts down, and 2'b00 and 2'b11 both hold. On a `done_i` pulse without a load, both pointers take their new value together one clock later.
- R5: Position code 3'b000 steps by the transfer width. Size code 2'b00 gives 1 byte, 2'b01 gives 2 bytes, and 2'b10 and 2'b11 give 4 bytes.
- R6: Position codes 3'b001, 3'b010, 3'b011 and 3'b100 step by 16, 256, 4096 and 65536 bytes, whatever the size code.
- R7: Position codes 3'b101 to 3'b111 step exactly as 3'b000 does.
- R8: `cfg_err_o` is 1 in the cycle after either position input holds a code from 3'b101 to 3'b111, and 0 in the cycle after both hold legal codes.
- R9: A pointer whose I/O flag (`src_io_i` or `dst_io_i`) is 1 does not change on `done_i`, whatever its direction code.
- R10: Address arithmetic wraps modulo 2^32 in both directions, and no flag is raised.
- R11: With neither `load_i` nor `done_i` high, both pointers keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load both start addresses |
| src_init_i | input | 32 | Source start address |
| dst_init_i | input | 32 | Destination start address |
| done_i | input | 1 | One transfer completed |
| size_i | input | 2 | Transfer width code |
| src_dir_i | input | 2 | Source direction code |
| dst_dir_i | input | 2 | Destination direction code |
| src_pos_i | input | 3 | Source step-position code |
| dst_pos_i | input | 3 | Destination step-position code |
| src_io_i | input | 1 | Source side is an I/O port (hold) |
| dst_io_i | input | 1 | Destination side is an I/O port (hold) |
| src_addr_o | output | 32 | Current source address |
| dst_addr_o | output | 32 | Current destination address |
| cfg_err_o | output | 1 | Reserved position code seen |

## Verification
The bench aims at these corner cases:
- A load and a done pulse in the same cycle. A design with the priority reversed would output a stepped start address.
- Counting down through zero and counting up past all-ones. A design with the wrong width or with saturation would stop at the limit instead of wrapping.
- Strided positions combined with every size code. A design that scaled the stride by the width would over-step by 2 or 4 times.
- Reserved position codes and I/O flags. A design that used these codes literally would produce odd steps, and a design that ignored the I/O flag would let a port address move.

Random stimulus mixes all of these and checks the results against a bench model.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10,
    DIR_RSV  = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSV  = 2'b11
  } size_e;

  localparam int unsigned PTR_COUNT = 2;
  localparam int unsigned PTR_SRC   = 0;
  localparam int unsigned PTR_DST   = 1;

endpackage

// File: rtl/dmaag_step_calc.sv
module dmaag_step_calc
  import dmaag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned POS_W      = 3,
  parameter int unsigned NUM_POS    = 5,
  parameter int unsigned POS_STRIDE = 4
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] step_o,
  output logic              reserved_o
);

  localparam int unsigned MAX_SHIFT = (NUM_POS - 1) * POS_STRIDE;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [1:0] width_shift;

  always_comb begin
    unique case (size_e'(size_i))
      SZ_BYTE: width_shift = 2'd0;
      SZ_HALF: width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  end

  always_comb begin
    reserved_o = (32'(pos_i) >= NUM_POS);
    if (pos_i == '0 || reserved_o) begin
      step_o = ONE << width_shift;
    end else begin
      step_o = ONE << (32'(pos_i) * POS_STRIDE);
    end
  end

  initial begin
    if (MAX_SHIFT >= ADDR_W) $error("stride exceeds address width");
  end

endmodule

// File: rtl/dmaag_pointer.sv
module dmaag_pointer
  import dmaag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] init_i,
  input  logic              done_i,
  input  logic [1:0]        dir_i,
  input  logic              io_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o
);

  dir_e             eff_dir;
  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    eff_dir = io_i ? DIR_HOLD : dir_e'(dir_i);
    unique case (eff_dir)
      DIR_UP:   next_addr = addr_o + step_i;
      DIR_DOWN: next_addr = addr_o - step_i;
      default:  next_addr = addr_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
    end else if (load_i) begin
      addr_o <= init_i;
    end else if (done_i) begin
      addr_o <= next_addr;
    end
  end

endmodule

// File: rtl/dmaag_addr_gen.sv
module dmaag_addr_gen
  import dmaag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned POS_W      = 3,
  parameter int unsigned NUM_POS    = 5,
  parameter int unsigned POS_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] src_init_i,
  input  logic [ADDR_W-1:0] dst_init_i,
  input  logic              done_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        src_dir_i,
  input  logic [1:0]        dst_dir_i,
  input  logic [POS_W-1:0]  src_pos_i,
  input  logic [POS_W-1:0]  dst_pos_i,
  input  logic              src_io_i,
  input  logic              dst_io_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              cfg_err_o
);

  logic [PTR_COUNT-1:0][ADDR_W-1:0] init_v;
  logic [PTR_COUNT-1:0][ADDR_W-1:0] addr_v;
  logic [PTR_COUNT-1:0][ADDR_W-1:0] step_v;
  logic [PTR_COUNT-1:0][POS_W-1:0]  pos_v;
  logic [PTR_COUNT-1:0][1:0]        dir_v;
  logic [PTR_COUNT-1:0]             io_v;
  logic [PTR_COUNT-1:0]             rsv_v;

  assign init_v[PTR_SRC] = src_init_i;
  assign init_v[PTR_DST] = dst_init_i;
  assign pos_v[PTR_SRC]  = src_pos_i;
  assign pos_v[PTR_DST]  = dst_pos_i;
  assign dir_v[PTR_SRC]  = src_dir_i;
  assign dir_v[PTR_DST]  = dst_dir_i;
  assign io_v[PTR_SRC]   = src_io_i;
  assign io_v[PTR_DST]   = dst_io_i;

  for (genvar g = 0; g < PTR_COUNT; g++) begin : g_ptr
    dmaag_step_calc #(
      .ADDR_W    (ADDR_W),
      .POS_W     (POS_W),
      .NUM_POS   (NUM_POS),
      .POS_STRIDE(POS_STRIDE)
    ) u_step (
      .pos_i     (pos_v[g]),
      .size_i    (size_i),
      .step_o    (step_v[g]),
      .reserved_o(rsv_v[g])
    );

    dmaag_pointer #(
      .ADDR_W(ADDR_W)
    ) u_ptr (
      .clk   (clk),
      .rst   (rst),
      .load_i(load_i),
      .init_i(init_v[g]),
      .done_i(done_i),
      .dir_i (dir_v[g]),
      .io_i  (io_v[g]),
      .step_i(step_v[g]),
      .addr_o(addr_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err_o <= 1'b0;
    end else begin
      cfg_err_o <= |rsv_v;
    end
  end

  assign src_addr_o = addr_v[PTR_SRC];
  assign dst_addr_o = addr_v[PTR_DST];

endmodule

// File: rtl/dmaag_checker.sv
module dmaag_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned POS_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [ADDR_W-1:0] src_init_i,
  input logic [ADDR_W-1:0] dst_init_i,
  input logic              done_i,
  input logic [1:0]        size_i,
  input logic [1:0]        src_dir_i,
  input logic [1:0]        dst_dir_i,
  input logic [POS_W-1:0]  src_pos_i,
  input logic [POS_W-1:0]  dst_pos_i,
  input logic              src_io_i,
  input logic              dst_io_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic [ADDR_W-1:0] dst_addr_o,
  input logic              cfg_err_o
);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (src_addr_o == '0 && dst_addr_o == '0 && !cfg_err_o)); // R1

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (src_addr_o == $past(src_init_i) && dst_addr_o == $past(dst_init_i))); // R3

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !done_i) |=> ($stable(src_addr_o) && $stable(dst_addr_o))); // R11

  AST_SRC_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && src_io_i) |=> $stable(src_addr_o)); // R9

  AST_DST_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && dst_io_i) |=> $stable(dst_addr_o)); // R9

  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (src_pos_i > 3'd4 || dst_pos_i > 3'd4) |=> cfg_err_o); // R8

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (src_pos_i <= 3'd4 && dst_pos_i <= 3'd4) |=> !cfg_err_o); // R8

  AST_WORD_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (done_i && !load_i && !src_io_i && src_dir_i == 2'b01 && src_pos_i == 3'd0 && size_i == 2'b10)
    |=> (src_addr_o == $past(src_addr_o) + ADDR_W'(4))); // R5

  AST_STRIDE_DOWN: assert property (@(posedge clk) disable iff (rst)
    (done_i && !load_i && !dst_io_i && dst_dir_i == 2'b10 && dst_pos_i == 3'd2)
    |=> (dst_addr_o == $past(dst_addr_o) - ADDR_W'(256))); // R6

endmodule

bind dmaag_addr_gen dmaag_checker #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_dmaag_chk (
  .clk       (clk),
  .rst       (rst),
  .load_i    (load_i),
  .src_init_i(src_init_i),
  .dst_init_i(dst_init_i),
  .done_i    (done_i),
  .size_i    (size_i),
  .src_dir_i (src_dir_i),
  .dst_dir_i (dst_dir_i),
  .src_pos_i (src_pos_i),
  .dst_pos_i (dst_pos_i),
  .src_io_i  (src_io_i),
  .dst_io_i  (dst_io_i),
  .src_addr_o(src_addr_o),
  .dst_addr_o(dst_addr_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/dmaag_addr_gen_bench.sv
module dmaag_addr_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst;
  logic        load_i;
  logic [31:0] src_init_i;
  logic [31:0] dst_init_i;
  logic        done_i;
  logic [1:0]  size_i;
  logic [1:0]  src_dir_i;
  logic [1:0]  dst_dir_i;
  logic [2:0]  src_pos_i;
  logic [2:0]  dst_pos_i;
  logic        src_io_i;
  logic        dst_io_i;
  logic [31:0] src_addr_o;
  logic [31:0] dst_addr_o;
  logic        cfg_err_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] m_src, m_dst;
  logic        m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaag_addr_gen u_dmaag_addr_gen (
    .clk(clk), .rst(rst), .load_i(load_i), .src_init_i(src_init_i),
    .dst_init_i(dst_init_i), .done_i(done_i), .size_i(size_i),
    .src_dir_i(src_dir_i), .dst_dir_i(dst_dir_i), .src_pos_i(src_pos_i),
    .dst_pos_i(dst_pos_i), .src_io_i(src_io_i), .dst_io_i(dst_io_i),
    .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o), .cfg_err_o(cfg_err_o)
  );

  function automatic logic [31:0] step_of(input logic [2:0] pos, input logic [1:0] sz);
    case (pos)
      3'd1: return 32'd16;
      3'd2: return 32'd256;
      3'd3: return 32'd4096;
      3'd4: return 32'd65536;
      default: begin
        if (sz == 2'b00) return 32'd1;
        else if (sz == 2'b01) return 32'd2;
        else return 32'd4;
      end
    endcase
  endfunction

  function automatic logic [31:0] advance(input logic [31:0] a, input logic [1:0] dir,
                                          input logic [2:0] pos, input logic [1:0] sz,
                                          input logic io);
    if (io) return a;
    if (dir == 2'b01) return a + step_of(pos, sz);
    if (dir == 2'b10) return a - step_of(pos, sz);
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // One clock: inputs already set; model follows; outputs sampled at negedge.
  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      m_src = '0; m_dst = '0; m_err = 1'b0;
    end else begin
      m_err = (src_pos_i > 3'd4) || (dst_pos_i > 3'd4);
      if (load_i) begin
        m_src = src_init_i; m_dst = dst_init_i;
      end else if (done_i) begin
        m_src = advance(m_src, src_dir_i, src_pos_i, size_i, src_io_i);
        m_dst = advance(m_dst, dst_dir_i, dst_pos_i, size_i, dst_io_i);
      end
    end
    @(negedge clk);
    chk({tag, " src"}, src_addr_o, m_src);
    chk({tag, " dst"}, dst_addr_o, m_dst);
    chk({tag, " err"}, 32'(cfg_err_o), 32'(m_err));
  endtask

  task automatic cfg(input logic [1:0] sz, input logic [1:0] sd, input logic [2:0] sp,
                     input logic [1:0] dd, input logic [2:0] dp);
    size_i = sz; src_dir_i = sd; src_pos_i = sp; dst_dir_i = dd; dst_pos_i = dp;
    src_io_i = 0; dst_io_i = 0;
  endtask

  task automatic do_load(input logic [31:0] s, input logic [31:0] d, input string tag);
    load_i = 1; done_i = 0; src_init_i = s; dst_init_i = d;
    tick(tag);
    load_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1; load_i = 0; done_i = 0; src_init_i = 0; dst_init_i = 0;
    cfg(2'b10, 2'b00, 3'd0, 2'b00, 3'd0);
    @(negedge clk);
    tick("R1 reset");
    tick("R1 reset");
    rst = 0;

    // R2 / R5 / R6: word source at bit 0, destination at bit 4
    cfg(2'b10, 2'b01, 3'd0, 2'b01, 3'd1);
    do_load(32'hA000_1000, 32'hB000_0000, "R2 load");
    chk("R2 first src", src_addr_o, 32'hA000_1000);
    done_i = 1;
    tick("R5 word up");
    chk("R5 src +4", src_addr_o, 32'hA000_1004);
    chk("R6 dst +16", dst_addr_o, 32'hB000_0010);
    tick("R4 both step");
    tick("R4 both step");
    chk("R5 src third", src_addr_o, 32'hA000_100C);
    chk("R6 dst third", dst_addr_o, 32'hB000_0030);

    // R11 idle
    done_i = 0;
    tick("R11 idle");
    chk("R11 src held", src_addr_o, 32'hA000_100C);

    // R3 load beats done
    load_i = 1; done_i = 1; src_init_i = 32'h1234_5678; dst_init_i = 32'h8765_4320;
    tick("R3 priority");
    chk("R3 src unstepped", src_addr_o, 32'h1234_5678);
    load_i = 0;

    // R10 wrap down, 16-bit destination at bit 0; source strided down at bit 8
    cfg(2'b01, 2'b10, 3'd2, 2'b10, 3'd0);
    do_load(32'hA000_1000, 32'h0000_0000, "R10 load");
    done_i = 1;
    tick("R10 wrap down");
    chk("R10 dst wrap", dst_addr_o, 32'hFFFF_FFFE);
    chk("R6 src -256", src_addr_o, 32'hA000_0F00);
    // wrap up
    cfg(2'b00, 2'b01, 3'd4, 2'b01, 3'd0);
    do_load(32'hFFFF_0000, 32'hFFFF_FFFF, "R10 load2");
    done_i = 1;
    tick("R10 wrap up");
    chk("R10 src wrap", src_addr_o, 32'h0000_0000);
    chk("R5 byte wrap", dst_addr_o, 32'h0000_0000);

    // R7 / R8 reserved positions
    cfg(2'b01, 2'b01, 3'd5, 2'b10, 3'd7);
    tick("R7 reserved");
    chk("R8 err set", 32'(cfg_err_o), 32'd1);
    chk("R7 src +2", src_addr_o, 32'h0000_0002);
    cfg(2'b01, 2'b01, 3'd0, 2'b01, 3'd3);
    tick("R8 clear");
    chk("R8 err clear", 32'(cfg_err_o), 32'd0);

    // R9 I/O hold, R4 code 11 hold
    cfg(2'b10, 2'b01, 3'd1, 2'b10, 3'd1);
    src_io_i = 1; dst_io_i = 1;
    do_load(32'h4000_0000, 32'h5000_0000, "R9 load");
    done_i = 1;
    tick("R9 io hold");
    chk("R9 src held", src_addr_o, 32'h4000_0000);
    chk("R9 dst held", dst_addr_o, 32'h5000_0000);
    cfg(2'b10, 2'b11, 3'd1, 2'b00, 3'd1);
    tick("R4 code11 hold");
    chk("R4 src held", src_addr_o, 32'h4000_0000);

    // Random mix
    for (int i = 0; i < RAND_CYCLES; i++) begin
      load_i = ($urandom_range(0, 9) == 0);
      done_i = ($urandom_range(0, 1) == 1);
      src_init_i = $urandom; dst_init_i = $urandom;
      size_i = 2'($urandom_range(0, 3));
      src_dir_i = 2'($urandom_range(0, 3)); dst_dir_i = 2'($urandom_range(0, 3));
      src_pos_i = 3'($urandom_range(0, 7)); dst_pos_i = 3'($urandom_range(0, 7));
      src_io_i = ($urandom_range(0, 6) == 0); dst_io_i = ($urandom_range(0, 6) == 0);
      tick("R4 random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule